// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core (32-bit MIPS Subset)

This block is a small in-order processor with five stages: fetch, decode, execute, memory access and writeback. It runs a fixed subset of the 32-bit MIPS integer instruction set. The instruction memory, data memory and 32-entry register file are all inside the block. The core has no interlock and no stall logic. Software must therefore place `nop` words where the forwarding network cannot cover a hazard, and after every branch.

There are two debug controls for a test environment. The program-load control freezes the pipeline and points the instruction-memory address at a manual address port, so that a program can be written in word by word. The dump control also freezes the pipeline. It points one register-file read port and the data-memory address at external dump addresses, so that the final architectural state can be read out. With both controls low, the core runs from address 0.

Top module: `mips5_core`

## Requirements
- R1: The decoder accepts exactly these instructions, with standard MIPS encodings: R-type opcode 0 with funct add 0x20, sub 0x22, and 0x24, or 0x25, nor 0x27, slt 0x2A, sltu 0x2B, sll 0x00 and srl 0x02; and opcodes addi 0x08, lw 0x23, lh 0x21, lhu 0x25, sw 0x2B and beq 0x04. Any other word changes no state. The all-zero word acts as a nop.
- R2: An ALU result is forwarded from the EX/MEM register to either ALU operand of the next instruction. Back-to-back dependent ALU instructions therefore need no nop.
- R3: The writeback value, including load data, is forwarded from the MEM/WB register to the execute stage. A load followed by one nop and then a dependent instruction sees the loaded value.
- R4: When both EX/MEM and MEM/WB target the register being read, the EX/MEM (younger) value wins.
- R5: Register 0 always reads as 0. Writes to it are discarded, and it is never a forwarding source.
- R6: beq resolves in execute and has no flush. The two instructions after it always execute. If the branch is taken, fetch continues at PC+4+sign-extended imm*4.
- R7: While the load control is high, a write strobe stores the data input at the instruction word given by the manual address. The PC holds and no architectural state changes. Execution starts at address 0 once the control drops.
- R8: While the dump control is high, the pipeline holds. The dump outputs give the register selected by the register dump address and the data word selected by the word dump address. Holding the dump control in the middle of a run does not change the final result.
- R9: lh sign-extends and lhu zero-extends a halfword chosen by byte-address bit 1. Bit 1 = 0 selects bits [15:0] and bit 1 = 1 selects bits [31:16] (little-endian). lw reads the whole word.
- R10: A register written in writeback is seen by an instruction reading it in decode in the same cycle (write-through).
- R11: sll and srl shift rt by the 5-bit shamt field. slt compares signed and sltu compares unsigned, each writing 1 or 0.
- R12: sw writes rt to the data word at byte address rs+imm, using word index address[7:2], and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_mode_i | input | 1 | Program-load control; freezes the core |
| load_we_i | input | 1 | Instruction-memory write strobe in load mode |
| load_addr_i | input | 6 | Manual instruction word address |
| load_data_i | input | 32 | Instruction word to store |
| dump_mode_i | input | 1 | Dump control; freezes the core |
| dump_reg_i | input | 5 | Register index to read out |
| dump_word_i | input | 6 | Data-memory word index to read out |
| dump_reg_o | output | 32 | Selected register value |
| dump_word_o | output | 32 | Selected data-memory word |

## Verification
The hardest case to reach is a read that two in-flight producers target at once, while a load result in MEM/WB and a write-through in decode also have to be resolved on the same instruction. The only port-level lever is the program itself. The stimulus is therefore one handcrafted program that writes the same register twice back to back and then reads it. It then follows a load with one nop and a dependent add, whose other operand is written back during that add's decode cycle. The program also places a taken branch, a not-taken branch and writes to register 0 so that every slot in the result is distinct. A freeze through the dump control in the middle of the run must leave the final dump unchanged.

// File: rtl/mips5_pkg.sv
package mips5_pkg;
  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SLT, ALU_SLTU
  } alu_op_e;

  typedef enum logic [1:0] {LD_W, LD_H, LD_HU} ld_kind_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rt;
    logic     use_imm;
    logic     mem_rd;
    logic     mem_wr;
    logic     is_beq;
    ld_kind_e ld_kind;
    alu_op_e  alu_op;
  } ctrl_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_LH    = 6'h21;
  localparam logic [5:0] OP_LHU   = 6'h25;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;

  localparam int unsigned XLEN = 32;
endpackage

// File: rtl/mips5_decode.sv
module mips5_decode
  import mips5_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o
);
  logic [5:0] op, fn;
  assign op = instr_i[31:26];
  assign fn = instr_i[5:0];

  always_comb begin
    ctrl_o = '0;
    ctrl_o.ld_kind = LD_W;
    ctrl_o.alu_op  = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        ctrl_o.reg_we = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_NOR:  ctrl_o.alu_op = ALU_NOR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          FN_SLTU: ctrl_o.alu_op = ALU_SLTU;
          FN_SLL:  ctrl_o.alu_op = ALU_SLL;
          FN_SRL:  ctrl_o.alu_op = ALU_SRL;
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.use_imm = 1'b1;
      end
      OP_LW, OP_LH, OP_LHU: begin
        ctrl_o.reg_we = 1'b1; ctrl_o.dst_rt = 1'b1; ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.ld_kind = (op == OP_LW) ? LD_W : (op == OP_LH) ? LD_H : LD_HU;
      end
      OP_SW: begin
        ctrl_o.use_imm = 1'b1; ctrl_o.mem_wr = 1'b1;
      end
      OP_BEQ: ctrl_o.is_beq = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mips5_alu.sv
module mips5_alu
  import mips5_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  alu_op_e          op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [4:0]       shamt_i,
  output logic [W-1:0]     y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_NOR:  y_o = ~(a_i | b_i);
      ALU_SLL:  y_o = b_i << shamt_i;
      ALU_SRL:  y_o = b_i >> shamt_i;
      ALU_SLT:  y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU: y_o = {{(W-1){1'b0}}, a_i < b_i};
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/mips5_regfile.sv
module mips5_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // write-through so writeback and decode may overlap
  assign rd_a_o = (we_i && wa_i != '0 && wa_i == ra_a_i) ? wd_i : regs_q[ra_a_i];
  assign rd_b_o = (we_i && wa_i != '0 && wa_i == ra_b_i) ? wd_i : regs_q[ra_b_i];

  a_r5_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);
endmodule

// File: rtl/mips5_core.sv
module mips5_core
  import mips5_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  localparam int unsigned IA_W = $clog2(IMEM_WORDS),
  localparam int unsigned DA_W = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_mode_i,
  input  logic            load_we_i,
  input  logic [IA_W-1:0] load_addr_i,
  input  logic [31:0]     load_data_i,
  input  logic            dump_mode_i,
  input  logic [4:0]      dump_reg_i,
  input  logic [DA_W-1:0] dump_word_i,
  output logic [31:0]     dump_reg_o,
  output logic [31:0]     dump_word_o
);
  logic run;
  assign run = !load_mode_i && !dump_mode_i;

  // ---------------- fetch ----------------
  logic [31:0]     imem [IMEM_WORDS];
  logic [31:0]     pc_q, pc_d, pc4_f, fetch_instr;
  logic [IA_W-1:0] imem_idx;
  logic            pc_ok;

  assign imem_idx = load_mode_i ? load_addr_i : pc_q[IA_W+1:2];
  assign pc_ok    = (pc_q[31:IA_W+2] == '0) && (pc_q[1:0] == 2'b00);
  assign fetch_instr = pc_ok ? imem[imem_idx] : 32'h0;
  assign pc4_f    = pc_q + 32'd4;

  always_ff @(posedge clk_i) begin
    if (load_mode_i && load_we_i) imem[imem_idx] <= load_data_i;
  end

  logic [31:0] ifid_instr_q, ifid_pc4_q;

  // ---------------- decode ----------------
  ctrl_t       id_ctrl;
  logic [4:0]  id_rs, id_rt, id_rd, id_dest, rf_ra_a;
  logic [31:0] id_rs_val, id_rt_val, id_imm;

  assign id_rs   = ifid_instr_q[25:21];
  assign id_rt   = ifid_instr_q[20:16];
  assign id_rd   = ifid_instr_q[15:11];
  assign id_imm  = {{16{ifid_instr_q[15]}}, ifid_instr_q[15:0]};
  assign id_dest = id_ctrl.dst_rt ? id_rt : id_rd;
  assign rf_ra_a = dump_mode_i ? dump_reg_i : id_rs;

  mips5_decode i_decode (.instr_i(ifid_instr_q), .ctrl_o(id_ctrl));

  logic        wb_we;
  logic [4:0]  wb_rd;
  logic [31:0] wb_val;

  mips5_regfile #(.W(32), .NREGS(32)) i_regfile (
    .clk_i, .rst_ni,
    .ra_a_i(rf_ra_a), .ra_b_i(id_rt),
    .rd_a_o(id_rs_val), .rd_b_o(id_rt_val),
    .we_i(wb_we && run), .wa_i(wb_rd), .wd_i(wb_val)
  );
  assign dump_reg_o = id_rs_val;

  ctrl_t       idex_ctrl_q;
  logic [4:0]  idex_rs_q, idex_rt_q, idex_dest_q, idex_shamt_q;
  logic [31:0] idex_a_q, idex_b_q, idex_imm_q, idex_pc4_q;

  // ---------------- execute ----------------
  ctrl_t       exm_ctrl_q;
  logic [4:0]  exm_rd_q;
  logic [31:0] exm_alu_q, exm_sdata_q;

  logic        fwd_exm_ok, fwd_wb_ok;
  logic [31:0] ex_a, ex_b, ex_alu_b, ex_y, br_target;
  logic        ex_taken;

  assign fwd_exm_ok = exm_ctrl_q.reg_we && exm_rd_q != '0;
  assign fwd_wb_ok  = wb_we && wb_rd != '0;

  always_comb begin
    ex_a = idex_a_q;
    if (fwd_exm_ok && exm_rd_q == idex_rs_q)   ex_a = exm_alu_q;
    else if (fwd_wb_ok && wb_rd == idex_rs_q)  ex_a = wb_val;
    ex_b = idex_b_q;
    if (fwd_exm_ok && exm_rd_q == idex_rt_q)   ex_b = exm_alu_q;
    else if (fwd_wb_ok && wb_rd == idex_rt_q)  ex_b = wb_val;
  end

  assign ex_alu_b  = idex_ctrl_q.use_imm ? idex_imm_q : ex_b;
  assign ex_taken  = idex_ctrl_q.is_beq && (ex_a == ex_b);
  assign br_target = idex_pc4_q + {idex_imm_q[29:0], 2'b00};
  assign pc_d      = ex_taken ? br_target : pc4_f;

  mips5_alu #(.W(32)) i_alu (
    .op_i(idex_ctrl_q.alu_op), .a_i(ex_a), .b_i(ex_alu_b),
    .shamt_i(idex_shamt_q), .y_o(ex_y)
  );

  // ---------------- memory ----------------
  logic [31:0]     dmem [DMEM_WORDS];
  logic [DA_W-1:0] dmem_idx;
  logic            dmem_ok;
  logic [31:0]     dmem_word, ld_half_ext, mem_ld;
  logic [15:0]     ld_half;

  assign dmem_idx  = dump_mode_i ? dump_word_i : exm_alu_q[DA_W+1:2];
  assign dmem_ok   = (exm_alu_q[31:DA_W+2] == '0) && !exm_alu_q[0];
  assign dmem_word = dmem[dmem_idx];
  assign dump_word_o = dmem_word;
  assign ld_half   = exm_alu_q[1] ? dmem_word[31:16] : dmem_word[15:0];
  assign ld_half_ext = (exm_ctrl_q.ld_kind == LD_H) ? {{16{ld_half[15]}}, ld_half}
                                                    : {16'h0, ld_half};
  assign mem_ld    = !dmem_ok ? 32'h0 :
                     (exm_ctrl_q.ld_kind == LD_W) ? dmem_word : ld_half_ext;

  always_ff @(posedge clk_i) begin
    if (run && exm_ctrl_q.mem_wr && dmem_ok && !exm_alu_q[1]) dmem[dmem_idx] <= exm_sdata_q;
  end

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ifid_instr_q <= '0; ifid_pc4_q <= '0;
      idex_ctrl_q <= '0; idex_rs_q <= '0; idex_rt_q <= '0; idex_dest_q <= '0;
      idex_shamt_q <= '0; idex_a_q <= '0; idex_b_q <= '0; idex_imm_q <= '0;
      idex_pc4_q <= '0;
      exm_ctrl_q <= '0; exm_rd_q <= '0; exm_alu_q <= '0; exm_sdata_q <= '0;
      wb_we <= 1'b0; wb_rd <= '0; wb_val <= '0;
    end else if (run) begin
      pc_q <= pc_d;
      ifid_instr_q <= fetch_instr;
      ifid_pc4_q   <= pc4_f;
      idex_ctrl_q  <= id_ctrl;
      idex_rs_q    <= id_rs;
      idex_rt_q    <= id_rt;
      idex_dest_q  <= id_dest;
      idex_shamt_q <= ifid_instr_q[10:6];
      idex_a_q     <= id_rs_val;
      idex_b_q     <= id_rt_val;
      idex_imm_q   <= id_imm;
      idex_pc4_q   <= ifid_pc4_q;
      exm_ctrl_q   <= idex_ctrl_q;
      exm_rd_q     <= idex_dest_q;
      exm_alu_q    <= ex_y;
      exm_sdata_q  <= ex_b;
      wb_we  <= exm_ctrl_q.reg_we;
      wb_rd  <= exm_rd_q;
      wb_val <= exm_ctrl_q.mem_rd ? mem_ld : exm_alu_q;
    end
  end

  // ---------------- assertions ----------------
  a_r7_load_holds_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_mode_i |=> $stable(pc_q));
  a_r8_dump_holds_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_mode_i |=> $stable(pc_q) && $stable(wb_val));
  a_r6_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ex_taken) |=> pc_q == $past(br_target));
  a_r9_lhu_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && exm_ctrl_q.mem_rd && exm_ctrl_q.ld_kind == LD_HU) |=> wb_val[31:16] == 16'h0);
  a_r12_store_no_regwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exm_ctrl_q.mem_wr |=> !wb_we);
endmodule

// File: tb/test_mips5_core.sv
`timescale 1ns/1ps
module test_mips5_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_mode = 1'b1, load_we = 1'b0, dump_mode = 1'b0;
  logic [5:0]  load_addr = '0, dump_word = '0;
  logic [31:0] load_data = '0;
  logic [4:0]  dump_reg = '0;
  logic [31:0] dump_reg_v, dump_word_v;

  always #2.5 clk = ~clk;

  mips5_core i_mips5_core (
    .clk_i(clk), .rst_ni(rst_n),
    .load_mode_i(load_mode), .load_we_i(load_we), .load_addr_i(load_addr),
    .load_data_i(load_data), .dump_mode_i(dump_mode), .dump_reg_i(dump_reg),
    .dump_word_i(dump_word), .dump_reg_o(dump_reg_v), .dump_word_o(dump_word_v)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  logic [31:0] prog [64];
  logic [31:0] e [32];

  task automatic dump_all_regs(string req);
    for (int r = 0; r < 32; r++) begin
      @(negedge clk); dump_reg = r[4:0]; #1;
      chk($sformatf("%s reg%0d", req, r), dump_reg_v, e[r]);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h08, 0, 1, 100);
    prog[1]  = enc_i(6'h08, 0, 2, -7);
    prog[2]  = enc_r(1, 2, 3, 0, 6'h20);    // R2 both operands forwarded
    prog[3]  = enc_r(3, 1, 3, 0, 6'h22);
    prog[4]  = enc_i(6'h08, 0, 5, 1);
    prog[5]  = enc_i(6'h08, 0, 5, 2);
    prog[6]  = enc_r(5, 5, 6, 0, 6'h20);    // R4 youngest wins
    prog[7]  = enc_r(1, 2, 7, 0, 6'h24);
    prog[8]  = enc_r(1, 2, 8, 0, 6'h25);
    prog[9]  = enc_r(1, 0, 9, 0, 6'h27);
    prog[10] = enc_r(0, 1, 10, 4, 6'h00);
    prog[11] = enc_r(0, 2, 11, 28, 6'h02);
    prog[12] = enc_r(2, 1, 12, 0, 6'h2A);
    prog[13] = enc_r(2, 1, 13, 0, 6'h2B);
    prog[14] = enc_i(6'h08, 0, 14, -32767);
    prog[15] = enc_r(0, 14, 14, 16, 6'h00);
    prog[16] = enc_i(6'h08, 0, 15, 32'h7FFE);
    prog[17] = enc_r(14, 15, 14, 0, 6'h25);
    prog[18] = enc_i(6'h2B, 0, 14, 8);      // R12 store, data forwarded
    prog[19] = enc_i(6'h21, 0, 16, 8);
    prog[20] = enc_i(6'h21, 0, 17, 10);
    prog[21] = enc_i(6'h25, 0, 18, 10);
    prog[22] = enc_i(6'h23, 0, 19, 8);
    prog[23] = 32'h0;
    prog[24] = enc_r(19, 18, 20, 0, 6'h20); // R3 load fwd, R10 write-through
    prog[25] = enc_i(6'h2B, 0, 20, 12);
    prog[26] = enc_i(6'h04, 1, 1, 3);       // R6 taken
    prog[27] = enc_i(6'h08, 0, 21, 11);
    prog[28] = enc_i(6'h08, 0, 22, 22);
    prog[29] = enc_i(6'h08, 0, 23, 33);
    prog[30] = enc_i(6'h04, 1, 2, 2);       // not taken
    prog[33] = enc_i(6'h08, 0, 24, 44);
    prog[34] = enc_i(6'h08, 0, 0, 5);       // R5
    prog[35] = enc_r(0, 1, 25, 0, 6'h20);
    prog[36] = enc_i(6'h04, 0, 0, -1);
    prog[40] = 32'hFC00_0000;               // R1 undefined opcode, never reached

    for (int r = 0; r < 32; r++) e[r] = 32'h0;

    #12; rst_n = 1'b1;
    // R8 reset state through dump
    @(negedge clk); dump_mode = 1'b1; load_mode = 1'b0;
    dump_all_regs("R8 reset");
    dump_mode = 1'b0; load_mode = 1'b1;

    // R7 load program
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); load_we = 1'b1; load_addr = i[5:0]; load_data = prog[i];
    end
    @(negedge clk); load_we = 1'b0;
    repeat (5) @(negedge clk);
    load_mode = 1'b0;

    // run, freeze in the middle, resume
    repeat (15) @(negedge clk);
    dump_mode = 1'b1; dump_reg = 5'd1; #1;
    chk("R8 mid-run r1", dump_reg_v, 32'd100);
    repeat (20) @(negedge clk);
    dump_mode = 1'b0;
    repeat (150) @(negedge clk);

    e[1] = 32'd100;
    e[2] = -32'sd7;
    e[3] = e[1] + e[2];
    e[3] = e[3] - e[1];
    e[5] = 32'd2;
    e[6] = e[5] + e[5];
    e[7] = e[1] & e[2];
    e[8] = e[1] | e[2];
    e[9] = ~e[1];
    e[10] = e[1] << 4;
    e[11] = e[2] >> 28;
    e[12] = ($signed(e[2]) < $signed(e[1])) ? 32'd1 : 32'd0;
    e[13] = (e[2] < e[1]) ? 32'd1 : 32'd0;
    e[15] = 32'h0000_7FFE;
    e[14] = ((32'h0 - 32'd32767) << 16) | e[15];
    e[16] = {{16{e[14][15]}}, e[14][15:0]};
    e[17] = {{16{e[14][31]}}, e[14][31:16]};
    e[18] = {16'h0, e[14][31:16]};
    e[19] = e[14];
    e[20] = e[19] + e[18];
    e[21] = 32'd11;
    e[22] = 32'd22;
    e[24] = 32'd44;
    e[25] = e[1];

    @(negedge clk); dump_mode = 1'b1;
    dump_all_regs("R1/R2/R3/R4/R5/R6/R9/R10/R11 final");
    dump_word = 6'd2; #1; chk("R12 word2", dump_word_v, e[14]);
    dump_word = 6'd3; #1; chk("R12 word3", dump_word_v, e[20]);
    dump_reg = 5'd6;  #1; chk("R4 r6", dump_reg_v, 32'd4);
    dump_reg = 5'd23; #1; chk("R6 skipped r23", dump_reg_v, 32'd0);
    dump_reg = 5'd17; #1; chk("R9 lh upper", dump_reg_v, 32'hFFFF_8001);
    dump_reg = 5'd0;  #1; chk("R5 r0", dump_reg_v, 32'd0);
    dump_reg = 5'd13; #1; chk("R11 sltu", dump_reg_v, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule